// File: doc/BRIEF.md
# Pin Function and Output Register Bank

This block is a memory-mapped controller for a bank of 54 general-purpose pins. A 32-bit register bus writes and reads a small word-addressed map. Through it software gives each pin a 3-bit function code, which makes the pin an input, a plain output or one of six alternate functions. Software also drives a per-pin output latch and reads back the synchronized pin levels.

The block drives three signals for each pin to the pad ring: the latched output value, an output enable, and the function code that the pad multiplexer decodes. Each register that holds one bit per pin is split at pin 32 into a low word and a high word. Address slots that the block does not implement read as zero and ignore writes.

Word address map: 0 to 5 hold the function select words and 6 is reserved. The output-set pair is at 7 and 8, with 9 reserved. The output-clear pair is at 10 and 11, with 12 reserved. The level pair is at 13 and 14, with 15 reserved. Addresses 16 to 31 are unused.

Top module: `pinmux_regbank`

## Requirements
- R1: After reset every function code is 000 (input) and every output latch is 0, so pad_out, pad_oe and pad_sel are all zero.
- R2: Select word w (address w, 0 to 5) holds the code of pin n = 10*w + k in bits 3k+2..3k. A read returns the stored codes. Bits 30 and 31 read as zero, and so do bits that map to no pin (bits 12 to 29 of word 5). A write affects only the pins of the word written.
- R3: pad_sel carries each pin's code at bits 3n+2..3n. pad_oe[n] is 1 only when the code is 001. The codes are 000 input, 001 output, 100 alt0, 101 alt1, 110 alt2, 111 alt3, 011 alt4 and 010 alt5, and no code other than 001 enables the output.
- R4: Writing the set words (address 7 for pins 0 to 31 at bits 0 to 31, address 8 for pins 32 to 53 at bits 0 to 21) sets the latch of every pin whose bit is 1. Zero bits leave the latch unchanged. pad_out shows the latches on the clock edge of the write.
- R5: Writing the clear words (address 10 for the low pins, address 11 for the high pins, with the same bit positions as R4) clears the latch of every pin whose bit is 1. Zero bits have no effect.
- R6: The set and clear words always read as zero.
- R7: The level words (address 13 for the low pins, address 14 for the high pins at bits 0 to 21) return pin_in through a two-flop synchronizer. A change becomes visible after exactly two rising edges. Bits 22 to 31 of address 14 read as zero.
- R8: Writes to the level words, the reserved words (6, 9, 12, 15) and the unused addresses 16 to 31 change no state. All reserved and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 54 | Raw pad input levels |
| pad_out | output | 54 | Output latch per pin |
| pad_oe | output | 54 | Output enable per pin |
| pad_sel | output | 162 | 3-bit function code per pin |

## Verification
The bench goes after the edges of the split layout. Word 5 holds only four pins, so a design that indexed it wrongly would show spurious bits in 12 to 29. The high set and clear words stop at bit 21, so a design that was off by one would disturb a neighbouring pin or leak ones into bits 22 to 31. It checks that only code 001 enables a driver; a design that decoded the most significant bit, or took the non-sequential alternate codes as outputs, would drive pads that should float. It reads the level words one cycle and two cycles after an input change, which exposes a synchronizer with the wrong depth. Writes to level, reserved and unused slots are shown to leave the pads and all readback unchanged.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 5;
    localparam int CODE_W        = 3;
    localparam int PINS_PER_WORD = 10;
    localparam int BANK_SPLIT    = 32;

    typedef enum logic [CODE_W-1:0] {
        FN_IN   = 3'b000,
        FN_OUT  = 3'b001,
        FN_ALT0 = 3'b100,
        FN_ALT1 = 3'b101,
        FN_ALT2 = 3'b110,
        FN_ALT3 = 3'b111,
        FN_ALT4 = 3'b011,
        FN_ALT5 = 3'b010
    } pin_fn_e;

    // Word addresses derived from the number of select words.
    function automatic int sel_words(int num_pins);
        return (num_pins + PINS_PER_WORD - 1) / PINS_PER_WORD;
    endfunction

    function automatic int addr_set_lo(int num_pins);
        return sel_words(num_pins) + 1;
    endfunction

    function automatic int addr_clr_lo(int num_pins);
        return sel_words(num_pins) + 4;
    endfunction

    function automatic int addr_lvl_lo(int num_pins);
        return sel_words(num_pins) + 7;
    endfunction

endpackage

// File: rtl/pinmux_fsel_bank.sv
module pinmux_fsel_bank
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_idx,
    input  logic [PINS_PER_WORD*CODE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]                 rd_idx,
    output logic [DATA_W-1:0]                 rd_word,
    output logic [NUM_PINS*CODE_W-1:0]        codes
);

    typedef struct packed {
        logic [NUM_PINS*CODE_W-1:0] code;
    } fsel_state_t;

    fsel_state_t fsel_d, fsel_q;

    always_comb begin
        fsel_d = fsel_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_en && (wr_idx == ADDR_W'(p / PINS_PER_WORD))) begin
                fsel_d.code[p*CODE_W +: CODE_W] =
                    wr_data[(p % PINS_PER_WORD)*CODE_W +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= '0;
        end else begin
            fsel_q <= fsel_d;
        end
    end

    // Read port: slots without a pin stay zero.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < PINS_PER_WORD; k++) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if ((p / PINS_PER_WORD == int'(rd_idx)) && (p % PINS_PER_WORD == k)) begin
                    rd_word[k*CODE_W +: CODE_W] = fsel_q.code[p*CODE_W +: CODE_W];
                end
            end
        end
    end

    assign codes = fsel_q.code;

endmodule

// File: rtl/pinmux_out_latch.sv
module pinmux_out_latch
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_lo,
    input  logic                set_hi,
    input  logic                clr_lo,
    input  logic                clr_hi,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] latch
);

    typedef struct packed {
        logic [NUM_PINS-1:0] val;
    } latch_state_t;

    latch_state_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p < BANK_SPLIT) begin
                if (set_lo && wr_data[p % BANK_SPLIT]) lat_d.val[p] = 1'b1;
                if (clr_lo && wr_data[p % BANK_SPLIT]) lat_d.val[p] = 1'b0;
            end else begin
                if (set_hi && wr_data[p % BANK_SPLIT]) lat_d.val[p] = 1'b1;
                if (clr_hi && wr_data[p % BANK_SPLIT]) lat_d.val[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign latch = lat_q.val;

endmodule

// File: rtl/pinmux_in_sync.sv
module pinmux_in_sync #(
    parameter int NUM_PINS = 54,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] ff;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d.ff[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.ff[s] = sync_q.ff[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.ff[STAGES-1];

endmodule

// File: rtl/pinmux_regbank.sv
module pinmux_regbank
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS    = 54,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS*CODE_W-1:0] pad_sel
);

    localparam int NUM_SEL = sel_words(NUM_PINS);
    localparam int HI_W    = NUM_PINS - BANK_SPLIT;
    localparam logic [ADDR_W-1:0] A_SET_LO = ADDR_W'(addr_set_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_SET_HI = ADDR_W'(addr_set_lo(NUM_PINS) + 1);
    localparam logic [ADDR_W-1:0] A_CLR_LO = ADDR_W'(addr_clr_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_CLR_HI = ADDR_W'(addr_clr_lo(NUM_PINS) + 1);
    localparam logic [ADDR_W-1:0] A_LVL_LO = ADDR_W'(addr_lvl_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_LVL_HI = ADDR_W'(addr_lvl_lo(NUM_PINS) + 1);

    logic                       sel_wr;
    logic [DATA_W-1:0]          sel_rd_word;
    logic [NUM_PINS*CODE_W-1:0] codes;
    logic [NUM_PINS-1:0]        level;

    assign sel_wr = bus_we && (int'(bus_addr) < NUM_SEL);

    pinmux_fsel_bank #(
        .NUM_PINS (NUM_PINS)
    ) u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr),
        .wr_idx  (bus_addr),
        .wr_data (bus_wdata[PINS_PER_WORD*CODE_W-1:0]),
        .rd_idx  (bus_addr),
        .rd_word (sel_rd_word),
        .codes   (codes)
    );

    pinmux_out_latch #(
        .NUM_PINS (NUM_PINS)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_lo  (bus_we && bus_addr == A_SET_LO),
        .set_hi  (bus_we && bus_addr == A_SET_HI),
        .clr_lo  (bus_we && bus_addr == A_CLR_LO),
        .clr_hi  (bus_we && bus_addr == A_CLR_HI),
        .wr_data (bus_wdata),
        .latch   (pad_out)
    );

    pinmux_in_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (level)
    );

    // Pad drive: only the plain output code enables the driver.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pad_oe[p] = (codes[p*CODE_W +: CODE_W] == FN_OUT);
    end

    assign pad_sel = codes;

    // Read mux; set, clear, reserved and unused slots return zero.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) < NUM_SEL) begin
            bus_rdata = sel_rd_word;
        end else if (bus_addr == A_LVL_LO) begin
            bus_rdata = level[BANK_SPLIT-1:0];
        end else if (bus_addr == A_LVL_HI) begin
            bus_rdata[HI_W-1:0] = level[NUM_PINS-1:BANK_SPLIT];
        end
    end

endmodule

// File: rtl/pinmux_regbank_chk.sv
module pinmux_regbank_chk
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_PINS-1:0]        pin_in,
    input logic [NUM_PINS-1:0]        pad_out,
    input logic [NUM_PINS-1:0]        pad_oe,
    input logic [NUM_PINS*CODE_W-1:0] pad_sel
);

    localparam int HI_W = NUM_PINS - BANK_SPLIT;
    localparam logic [ADDR_W-1:0] A_SET_LO = ADDR_W'(addr_set_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_CLR_LO = ADDR_W'(addr_clr_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_LVL_LO = ADDR_W'(addr_lvl_lo(NUM_PINS));
    localparam logic [ADDR_W-1:0] A_LVL_HI = ADDR_W'(addr_lvl_lo(NUM_PINS) + 1);

    // Edges seen since reset release, saturating.
    logic [1:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges_q <= '0;
        else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
    end

    a_r2_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0) |=> pad_sel[CODE_W-1:0] == $past(bus_wdata[CODE_W-1:0]));

    a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) < sel_words(NUM_PINS)) |-> bus_rdata[DATA_W-1:DATA_W-2] == 2'b00);

    a_r3_pad0_oe: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] == (pad_sel[CODE_W-1:0] == 3'b001));

    a_r3_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_sel) && $stable(pad_oe)));

    a_r4_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET_LO) |=>
        (pad_out[BANK_SPLIT-1:0] & $past(bus_wdata)) == $past(bus_wdata));

    a_r4_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_out));

    a_r5_clr_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR_LO) |=>
        (pad_out[BANK_SPLIT-1:0] & $past(bus_wdata)) == '0);

    a_r6_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SET_LO || bus_addr == A_CLR_LO) |-> bus_rdata == '0);

    a_r7_level_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd3 && bus_addr == A_LVL_LO) |->
        bus_rdata == $past(pin_in[BANK_SPLIT-1:0], 2));

    a_r7_level_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd3 && bus_addr == A_LVL_HI) |->
        bus_rdata == {{(DATA_W-HI_W){1'b0}}, $past(pin_in[NUM_PINS-1:BANK_SPLIT], 2)});

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > int'(A_LVL_HI)) |-> bus_rdata == '0);

endmodule

bind pinmux_regbank pinmux_regbank_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_sel   (pad_sel)
);

// File: tb/test_pinmux_regbank.sv
module test_pinmux_regbank;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [NP*3-1:0] pad_sel;

    int n_checks = 0;
    int n_errors = 0;

    // Bench model
    logic [2:0]    m_code [NP];
    logic [NP-1:0] m_lat;
    logic [NP-1:0] m_pin;

    pinmux_regbank i_pinmux_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_sel(pad_sel)
    );

    always #10 clk = ~clk;

    initial begin
        #(200000 * 20);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] w = '0;
        if (a < 6) begin
            for (int k = 0; k < 10; k++)
                if (a*10 + k < NP) w[k*3 +: 3] = m_code[a*10 + k];
        end else if (a == 13) w = m_pin[31:0];
        else if (a == 14) w[NP-33:0] = m_pin[NP-1:32];
        return w;
    endfunction

    function automatic logic [NP*3-1:0] exp_sel();
        logic [NP*3-1:0] s;
        for (int p = 0; p < NP; p++) s[p*3 +: 3] = m_code[p];
        return s;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] o;
        for (int p = 0; p < NP; p++) o[p] = (m_code[p] == 3'b001);
        return o;
    endfunction

    task automatic model_wr(input int a, input logic [31:0] d);
        if (a < 6) begin
            for (int k = 0; k < 10; k++)
                if (a*10 + k < NP) m_code[a*10 + k] = d[k*3 +: 3];
        end
        for (int p = 0; p < NP; p++) begin
            if (a == 7  && p < 32  && d[p])      m_lat[p] = 1'b1;
            if (a == 8  && p >= 32 && d[p-32])   m_lat[p] = 1'b1;
            if (a == 10 && p < 32  && d[p])      m_lat[p] = 1'b0;
            if (a == 11 && p >= 32 && d[p-32])   m_lat[p] = 1'b0;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_check(input string tag, input int a);
        bus_addr = 5'(a);
        #1;
        check(tag, 256'(bus_rdata), 256'(exp_rd(a)));
    endtask

    task automatic pads_check(input string tag);
        #1;
        check({tag, " pad_out"}, 256'(pad_out), 256'(m_lat));
        check({tag, " pad_oe"},  256'(pad_oe),  256'(exp_oe()));
        check({tag, " pad_sel"}, 256'(pad_sel), 256'(exp_sel()));
    endtask

    initial begin
        logic [31:0] snap [32];
        logic [2:0] fn_list [8];
        logic [31:0] d;
        fn_list = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111, 3'b011, 3'b010};
        for (int p = 0; p < NP; p++) m_code[p] = 3'b000;
        m_lat = '0; m_pin = '0;
        void'($urandom(32'd20250417));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        pads_check("R1 reset");
        rd_check("R1 reset sel word 0", 0);

        // R2 full word readback, top bits and pinless bits zero
        wr(0, 32'hFFFF_FFFF);
        rd_check("R2 word0 bits 30/31", 0);
        wr(5, 32'hFFFF_FFFF);
        rd_check("R2 word5 only four pins", 5);
        pads_check("R2 after all-ones");
        wr(3, 32'h1234_5678);
        rd_check("R2 word3 pattern", 3);
        rd_check("R2 word0 untouched", 0);

        // R3 every code on pins 0..7; only 001 enables
        d = '0;
        for (int k = 0; k < 8; k++) d[k*3 +: 3] = fn_list[k];
        wr(0, d);
        pads_check("R3 code set");
        check("R3 oe only pin1", 256'(pad_oe[9:0]), 256'(10'b00_0000_0010));

        // R4 set, zero bits leave state
        wr(7, 32'h8000_0001);
        pads_check("R4 set lo");
        wr(8, 32'hFFFF_FFFF);
        pads_check("R4 set hi upper bits ignored");
        wr(7, 32'h0000_0000);
        pads_check("R4 zero set no effect");

        // R6 set and clear read zero
        rd_check("R6 set lo reads zero", 7);
        rd_check("R6 set hi reads zero", 8);
        rd_check("R6 clr lo reads zero", 10);
        rd_check("R6 clr hi reads zero", 11);

        // R5 clear
        wr(11, 32'h0020_0001);
        pads_check("R5 clear hi edges");
        wr(10, 32'h0000_0001);
        pads_check("R5 clear lo");
        wr(10, 32'h0000_0000);
        pads_check("R5 zero clear no effect");

        // R7 level synchronizer depth
        pin_in = {22'h2A_AAAA, 32'hDEAD_BEEF};
        bus_addr = 5'd13; #1;
        check("R7 zero edges old", 256'(bus_rdata), 256'(0));
        @(negedge clk);
        bus_addr = 5'd13; #1;
        check("R7 one edge still old", 256'(bus_rdata), 256'(0));
        @(negedge clk);
        m_pin = pin_in;
        rd_check("R7 two edges lo", 13);
        rd_check("R7 two edges hi", 14);

        // R8 ignored writes
        for (int a = 0; a < 32; a++) begin
            bus_addr = 5'(a); #1; snap[a] = bus_rdata;
        end
        foreach (fn_list[i]) begin end
        wr(13, 32'hFFFF_FFFF); wr(14, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);  wr(9, 32'hFFFF_FFFF);
        wr(12, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
        wr(16, 32'hFFFF_FFFF); wr(31, 32'hFFFF_FFFF);
        pads_check("R8 ignored writes pads");
        for (int a = 0; a < 32; a++) begin
            bus_addr = 5'(a); #1;
            check($sformatf("R8 readback unchanged addr %0d", a), 256'(bus_rdata), 256'(snap[a]));
            check($sformatf("R8 model addr %0d", a), 256'(bus_rdata), 256'(exp_rd(a)));
        end

        // Random mix (R2 R3 R4 R5 R7 R8)
        for (int it = 0; it < 800; it++) begin
            int a;
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 4)      a = int'($urandom_range(0, 5));
            else if (pick < 8) a = 7 + 3 * int'($urandom_range(0, 1)) + int'($urandom_range(0, 1));
            else               a = int'($urandom_range(0, 31));
            wr(a, $urandom());
            if ($urandom_range(0, 7) == 0) begin
                pin_in = {$urandom(), $urandom()};
                repeat (2) @(negedge clk);
                m_pin = pin_in;
            end
            pads_check("R3 R4 R5 random");
            rd_check("R2 R7 R8 random read", int'($urandom_range(0, 31)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule